// File: doc/BRIEF.md
# Accumulator Stored-Program Processor Core

This block is a compact processor that executes 16-bit instructions from a word-addressed synchronous memory. Each instruction is fetched, decoded and executed as a short series of register transfers. All addresses pass through an address-holding register, and all data passes through a data-holding register. One accumulator is the only working register. The core supports the following:

- direct load, store, add and subtract;
- an indirect add through a pointer word;
- a call that saves its return address in memory, and a return through a memory word;
- an unconditional jump;
- a conditional skip;
- accumulator clear;
- byte input and byte output ports;
- a halt state.

The memory port presents an address, write data, a write enable and a read strobe. The word read appears on the read-data input on the cycle after the strobe. An instruction word holds a 4-bit opcode in bits 15..12 and a 12-bit address in bits 11..0. The opcodes are:

| Opcode | Operation |
|---|---|
| 0 | call |
| 1 | load |
| 2 | store |
| 3 | add |
| 4 | subtract |
| 5 | input |
| 6 | output |
| 7 | halt |
| 8 | skip |
| 9 | jump |
| A | clear |
| B | indirect add |
| C | indirect jump |
| D, E, F | no-op |

Top module: `accum_cpu`

## Requirements
- R1: While reset is low, halted, out_strobe, mem_re and mem_we are 0. After reset is released, the first memory read is of address 0.
- R2: Each fetch reads the word at the program counter with one cycle of read latency, and the program counter advances by one before the instruction executes.
- R3: Load (1) copies M[X] to the accumulator and store (2) writes the accumulator to M[X]. Add (3) and subtract (4) compute AC+M[X] and AC−M[X] modulo 2^16, so 0x7FFF+1 gives 0x8000 and 0−1 gives 0xFFFF.
- R4: Indirect add (B) reads M[X], uses bits 11..0 of that word as an address, and adds the word found there to the accumulator.
- R5: Skip (8) looks at instruction bits 11..10. With 00 it skips the next instruction when AC is negative, with 01 when AC is zero, and with 10 when AC is above zero. With 11 it never skips.
- R6: Jump (9) sets the program counter to X. Call (0) writes the return address, zero-extended, to M[X] and continues at X+1. Indirect jump (C) loads the program counter from bits 11..0 of M[X].
- R7: Clear (A) sets the accumulator to 0x0000.
- R8: Input (5) waits while in_valid is low, making no memory access. It then loads the accumulator with in_data zero-extended to 16 bits.
- R9: Output (6) places AC[7:0] on out_data and raises out_strobe for exactly one cycle per instruction.
- R10: Halt (7) raises halted. halted stays high until reset, and the core then makes no memory access.
- R11: Program counter and address arithmetic wrap modulo 4096, so execution continues from 0x000 after 0xFFF. Opcodes D, E and F change nothing except the program counter.
- R12: mem_re and mem_we are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Word address to memory |
| mem_wdata | output | 16 | Word to be written |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read strobe; data returns next cycle |
| mem_rdata | input | 16 | Word read from memory |
| in_data | input | 8 | Input port byte |
| in_valid | input | 1 | Input byte available |
| out_data | output | 8 | Output port byte |
| out_strobe | output | 1 | One-cycle pulse when out_data is updated |
| halted | output | 1 | Core has executed halt |

## Verification
The assertions assume a memory that returns, on the cycle after mem_re, the word last written at that address. The testbench memory model is built to meet exactly that contract. in_valid is treated as an arbitrary level that may change on any cycle, so the bench toggles it at random and also holds it low or high for long stretches. Random programs are restricted to code below a fixed data area and always end in halt instructions, so every program terminates.

// File: rtl/accum_cpu_pkg.sv
package accum_cpu_pkg;

  typedef enum logic [3:0] {
    OP_CALL  = 4'h0,
    OP_LOAD  = 4'h1,
    OP_STORE = 4'h2,
    OP_ADD   = 4'h3,
    OP_SUB   = 4'h4,
    OP_IN    = 4'h5,
    OP_OUT   = 4'h6,
    OP_HALT  = 4'h7,
    OP_SKIP  = 4'h8,
    OP_JUMP  = 4'h9,
    OP_CLR   = 4'hA,
    OP_ADDI  = 4'hB,
    OP_JUMPI = 4'hC
  } opcode_t;

  typedef enum logic [4:0] {
    S_FETCH0, S_FETCH1, S_FETCH2, S_DECODE,
    S_RD1, S_RD1W, S_IND, S_RD2, S_RD2W, S_EXEC,
    S_ST0, S_ST1, S_CALL0, S_CALL1,
    S_INWAIT, S_INLOAD, S_HALT
  } state_t;

  typedef enum logic [1:0] {
    ALU_PASS, ALU_ADD, ALU_SUB, ALU_ZERO
  } alu_op_t;

  typedef struct packed {
    logic    mar_from_pc;
    logic    mar_from_ir;
    logic    mar_from_mbr;
    logic    mbr_from_mem;
    logic    mbr_from_ac;
    logic    mbr_from_pc;
    logic    ir_load;
    logic    pc_inc;
    logic    pc_from_ir;
    logic    pc_from_mbr;
    logic    pc_from_mar1;
    logic    skip_test;
    logic    ac_from_alu;
    logic    ac_from_in;
    logic    in_load;
    logic    out_load;
    logic    mem_re;
    logic    mem_we;
    logic    halted;
    alu_op_t alu_op;
  } ctrl_t;

endpackage

// File: rtl/accum_cpu_alu.sv
module accum_cpu_alu
  import accum_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_t           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        skip_code,
  output logic [DATA_W-1:0] y,
  output logic              skip_hit
);

  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] z);
    return x + z;
  endfunction

  function automatic logic [DATA_W-1:0] wrap_sub(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] z);
    return x - z;
  endfunction

  function automatic logic cond_met(input logic [DATA_W-1:0] x,
                                    input logic [1:0] code);
    logic neg, zero;
    neg  = x[DATA_W-1];
    zero = (x == '0);
    case (code)
      2'b00:   return neg;
      2'b01:   return zero;
      2'b10:   return !neg && !zero;
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    case (op)
      ALU_ADD:  y = wrap_add(a, b);
      ALU_SUB:  y = wrap_sub(a, b);
      ALU_ZERO: y = '0;
      default:  y = b;
    endcase
  end

  assign skip_hit = cond_met(a, skip_code);

  always_comb begin
    // R5
    if (skip_code == 2'b11) skip_never_chk: assert (!skip_hit);
    // R5
    if (a == '0 && skip_code != 2'b01) skip_zero_chk: assert (!skip_hit);
  end

endmodule

// File: rtl/accum_cpu_ctrl.sv
module accum_cpu_ctrl
  import accum_cpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opcode_t opcode,
  input  logic    in_valid,
  output ctrl_t   ctl,
  output logic    in_waiting
);

  state_t state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_FETCH0;
    else        state_q <= state_d;
  end

  always_comb begin
    ctl     = '0;
    state_d = state_q;
    case (state_q)
      S_FETCH0: begin ctl.mar_from_pc = 1'b1; state_d = S_FETCH1; end
      S_FETCH1: begin ctl.mem_re = 1'b1; state_d = S_FETCH2; end
      S_FETCH2: begin
        ctl.ir_load = 1'b1;
        ctl.pc_inc  = 1'b1;
        state_d     = S_DECODE;
      end
      S_DECODE: begin
        state_d = S_FETCH0;
        case (opcode)
          OP_CALL:  begin ctl.mar_from_ir = 1'b1; state_d = S_CALL0; end
          OP_LOAD, OP_ADD, OP_SUB, OP_ADDI, OP_JUMPI: begin
            ctl.mar_from_ir = 1'b1;
            state_d         = S_RD1;
          end
          OP_STORE: begin ctl.mar_from_ir = 1'b1; state_d = S_ST0; end
          OP_IN:    state_d = S_INWAIT;
          OP_OUT:   ctl.out_load = 1'b1;
          OP_HALT:  state_d = S_HALT;
          OP_SKIP:  ctl.skip_test = 1'b1;
          OP_JUMP:  ctl.pc_from_ir = 1'b1;
          OP_CLR:   begin ctl.ac_from_alu = 1'b1; ctl.alu_op = ALU_ZERO; end
          default:  state_d = S_FETCH0;
        endcase
      end
      S_RD1:  begin ctl.mem_re = 1'b1; state_d = S_RD1W; end
      S_RD1W: begin
        ctl.mbr_from_mem = 1'b1;
        state_d = (opcode == OP_ADDI) ? S_IND : S_EXEC;
      end
      S_IND:  begin ctl.mar_from_mbr = 1'b1; state_d = S_RD2; end
      S_RD2:  begin ctl.mem_re = 1'b1; state_d = S_RD2W; end
      S_RD2W: begin ctl.mbr_from_mem = 1'b1; state_d = S_EXEC; end
      S_EXEC: begin
        state_d = S_FETCH0;
        case (opcode)
          OP_LOAD:  begin ctl.ac_from_alu = 1'b1; ctl.alu_op = ALU_PASS; end
          OP_ADD,
          OP_ADDI:  begin ctl.ac_from_alu = 1'b1; ctl.alu_op = ALU_ADD; end
          OP_SUB:   begin ctl.ac_from_alu = 1'b1; ctl.alu_op = ALU_SUB; end
          OP_JUMPI: ctl.pc_from_mbr = 1'b1;
          default:  ctl.alu_op = ALU_PASS;
        endcase
      end
      S_ST0:   begin ctl.mbr_from_ac = 1'b1; state_d = S_ST1; end
      S_ST1:   begin ctl.mem_we = 1'b1; state_d = S_FETCH0; end
      S_CALL0: begin ctl.mbr_from_pc = 1'b1; state_d = S_CALL1; end
      S_CALL1: begin
        ctl.mem_we       = 1'b1;
        ctl.pc_from_mar1 = 1'b1;
        state_d          = S_FETCH0;
      end
      S_INWAIT: if (in_valid) begin ctl.in_load = 1'b1; state_d = S_INLOAD; end
      S_INLOAD: begin ctl.ac_from_in = 1'b1; state_d = S_FETCH0; end
      S_HALT:   ctl.halted = 1'b1;
      default:  state_d = S_FETCH0;
    endcase
  end

  assign in_waiting = (state_q == S_INWAIT);

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_HALT |=> state_q == S_HALT);

  // R2
  decode_follows_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ir_load |=> state_q == S_DECODE);

endmodule

// File: rtl/accum_cpu.sv
module accum_cpu
  import accum_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int IO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [IO_W-1:0]   in_data,
  input  logic              in_valid,
  output logic [IO_W-1:0]   out_data,
  output logic              out_strobe,
  output logic              halted
);

  localparam int OPC_W  = 4;
  localparam int PAD_PC = DATA_W - ADDR_W;
  localparam int PAD_IO = DATA_W - IO_W;

  ctrl_t             ctl;
  logic              in_waiting;
  logic [DATA_W-1:0] ac, mbr, ir, alu_y;
  logic [ADDR_W-1:0] pc, mar;
  logic [IO_W-1:0]   inp_q, out_q;
  logic              out_stb_q;
  logic              skip_hit;
  logic              pc_step;

  wire opcode_t             opcode    = opcode_t'(ir[DATA_W-1 -: OPC_W]);
  wire logic [ADDR_W-1:0]   addr_fld  = ir[ADDR_W-1:0];
  wire logic [1:0]          skip_code = ir[ADDR_W-1 -: 2];

  accum_cpu_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (opcode),
    .in_valid   (in_valid),
    .ctl        (ctl),
    .in_waiting (in_waiting)
  );

  accum_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op        (ctl.alu_op),
    .a         (ac),
    .b         (mbr),
    .skip_code (skip_code),
    .y         (alu_y),
    .skip_hit  (skip_hit)
  );

  assign pc_step = ctl.pc_inc || (ctl.skip_test && skip_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mar <= '0;
    else if (ctl.mar_from_pc)  mar <= pc;
    else if (ctl.mar_from_ir)  mar <= addr_fld;
    else if (ctl.mar_from_mbr) mar <= mbr[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mbr <= '0;
    else if (ctl.mbr_from_mem) mbr <= mem_rdata;
    else if (ctl.mbr_from_ac)  mbr <= ac;
    else if (ctl.mbr_from_pc)  mbr <= {{PAD_PC{1'b0}}, pc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir <= '0;
    else if (ctl.ir_load) ir <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else if (pc_step)          pc <= pc + 1'b1;
    else if (ctl.pc_from_ir)   pc <= addr_fld;
    else if (ctl.pc_from_mbr)  pc <= mbr[ADDR_W-1:0];
    else if (ctl.pc_from_mar1) pc <= mar + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ac <= '0;
    else if (ctl.ac_from_alu) ac <= alu_y;
    else if (ctl.ac_from_in)  ac <= {{PAD_IO{1'b0}}, inp_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inp_q <= '0;
    else if (ctl.in_load) inp_q <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= '0;
      out_stb_q <= 1'b0;
    end else begin
      out_stb_q <= ctl.out_load;
      if (ctl.out_load) out_q <= ac[IO_W-1:0];
    end
  end

  assign mem_addr   = mar;
  assign mem_wdata  = mbr;
  assign mem_re     = ctl.mem_re;
  assign mem_we     = ctl.mem_we;
  assign out_data   = out_q;
  assign out_strobe = out_stb_q;
  assign halted     = ctl.halted;

  // R12
  excl_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_re && !mem_we));

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R9
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |=> !out_strobe);

  // R8
  in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_waiting && !in_valid) |=> ($stable(ac) && !mem_re && !mem_we));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ir_load |=> (pc == $past(pc) + 1'b1));

  // R2
  ir_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ir_load |=> (ir == $past(mem_rdata)));

endmodule

// File: tb/accum_cpu_test.sv
module accum_cpu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we, mem_re;
  logic [15:0] mem_rdata = '0;
  logic [7:0]  in_val = 8'h00;
  logic [7:0]  in_data;
  logic        in_valid = 1'b0;
  logic [7:0]  out_data;
  logic        out_strobe, halted;

  assign in_data = in_val;

  accum_cpu uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .in_data(in_data), .in_valid(in_valid), .out_data(out_data),
    .out_strobe(out_strobe), .halted(halted)
  );

  always #10 clk = ~clk;

  logic [15:0] mem     [4096];
  logic [15:0] img     [4096];
  logic [15:0] ref_mem [4096];
  logic [7:0]  ref_out [1024];
  int          ref_nout;
  logic [7:0]  cap [2048];
  int          cap_total = 0;
  int          acc_count = 0;
  logic        load_req = 1'b0;
  int          in_mode = 0;
  int          n_checks = 0;
  int          n_errors = 0;
  int          cap0, acc0;

  always @(posedge clk) begin
    if (load_req) begin
      for (int i = 0; i < 4096; i++) mem[i] <= img[i];
    end else begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
    end
  end

  always @(posedge clk) begin
    if (out_strobe) begin
      cap[cap_total % 2048] = out_data;
      cap_total++;
    end
    if (mem_re || mem_we) acc_count++;
  end

  always @(negedge clk) begin
    case (in_mode)
      1:       in_valid <= 1'b0;
      2:       in_valid <= 1'b1;
      default: in_valid <= ($urandom % 3 == 0);
    endcase
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input int op, input int x);
    return {op[3:0], x[11:0]};
  endfunction

  task automatic iss_run();
    logic [11:0] pc = '0;
    logic [15:0] ac = '0;
    logic [15:0] w;
    logic [11:0] x;
    bit run = 1'b1;
    int steps = 0;
    ref_nout = 0;
    while (run && steps < 5000) begin
      w = ref_mem[pc];
      pc = pc + 12'd1;
      steps++;
      x = w[11:0];
      case (w[15:12])
        4'h0: begin ref_mem[x] = {4'h0, pc}; pc = x + 12'd1; end
        4'h1: ac = ref_mem[x];
        4'h2: ref_mem[x] = ac;
        4'h3: ac = ac + ref_mem[x];
        4'h4: ac = ac - ref_mem[x];
        4'h5: ac = {8'h00, in_val};
        4'h6: begin ref_out[ref_nout] = ac[7:0]; ref_nout++; end
        4'h7: run = 1'b0;
        4'h8: case (x[11:10])
                2'b00: if (ac[15]) pc = pc + 12'd1;
                2'b01: if (ac == 16'h0) pc = pc + 12'd1;
                2'b10: if (!ac[15] && ac != 16'h0) pc = pc + 12'd1;
                default: ;
              endcase
        4'h9: pc = x;
        4'hA: ac = 16'h0;
        4'hB: ac = ac + ref_mem[ref_mem[x][11:0]];
        4'hC: pc = ref_mem[x][11:0];
        default: ;
      endcase
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 4096; i++) img[i] = 16'h0;
  endtask

  task automatic start_prog();
    int n;
    for (int i = 0; i < 4096; i++) ref_mem[i] = img[i];
    iss_run();
    @(negedge clk);
    rst_n = 1'b0;
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    chk(!halted && !mem_re && !mem_we && !out_strobe, "R1", "outputs in reset",
        {halted, mem_re, mem_we, out_strobe}, 0);
    cap0 = cap_total;
    acc0 = acc_count;
    rst_n = 1'b1;
    n = 0;
    while (!mem_re && n < 10) begin @(negedge clk); n++; end
    chk(mem_re && mem_addr == 12'h000, "R1", "first fetch address", mem_addr, 0);
  endtask

  task automatic finish_prog();
    int n = 0;
    int acc_mark, bad, first_bad;
    while (!halted && n < 20000) begin @(negedge clk); n++; end
    chk(halted, "R10", "halt reached (watchdog)", halted, 1);
    if (!halted) return;
    acc_mark = acc_count;
    repeat (20) @(negedge clk);
    chk(halted && acc_count == acc_mark, "R10", "halted holds, bus idle",
        acc_count - acc_mark, 0);
    bad = 0;
    first_bad = -1;
    for (int i = 0; i < 4096; i++)
      if (mem[i] !== ref_mem[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    if (first_bad >= 0)
      chk(1'b0, "R3", $sformatf("memory word %0h", first_bad),
          mem[first_bad], ref_mem[first_bad]);
    else chk(1'b1, "R3", "memory image", 0, 0);
    chk(cap_total - cap0 == ref_nout, "R9", "output strobe count",
        cap_total - cap0, ref_nout);
    bad = 0;
    for (int i = 0; i < ref_nout && i < cap_total - cap0; i++)
      if (cap[(cap0 + i) % 2048] !== ref_out[i] && bad == 0) begin
        bad = 1;
        chk(1'b0, "R9", $sformatf("output byte %0d", i),
            cap[(cap0 + i) % 2048], ref_out[i]);
      end
    if (bad == 0) chk(1'b1, "R9", "output bytes", 0, 0);
  endtask

  function automatic logic [15:0] pick_data();
    case ($urandom % 6)
      0: return 16'h0000;
      1: return 16'h7FFF;
      2: return 16'h8000;
      3: return 16'hFFFF;
      4: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic gen_random();
    int n;
    int op;
    clear_img();
    for (int i = 0; i < 16; i++) img[12'h100 + i] = pick_data();
    for (int i = 0; i < 4; i++) img[12'h110 + i] = 16'h0100 + 16'($urandom % 16);
    for (n = 0; n < 24; n++) begin
      op = $urandom % 11;
      case (op)
        0: img[n] = ins(1, 12'h100 + $urandom % 16);
        1: img[n] = ins(3, 12'h100 + $urandom % 16);
        2: img[n] = ins(4, 12'h100 + $urandom % 16);
        3: img[n] = ins(2, 12'h100 + $urandom % 16);
        4: img[n] = ins(11, 12'h110 + $urandom % 4);
        5: img[n] = ins(10, 0);
        6: img[n] = ins(8, $urandom % 4096);
        7: img[n] = ins(6, 0);
        8: img[n] = ins(5, 0);
        9: img[n] = ins(13 + $urandom % 3, $urandom % 4096);
        default: img[n] = ins(8, ($urandom % 4) << 10);
      endcase
    end
    img[24] = ins(2, 12'h120);
    img[25] = ins(7, 0);
    img[26] = ins(7, 0);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    clear_img();
    repeat (3) @(negedge clk);

    // R4 R5 R9: indirect summing loop with negative-test skip
    clear_img();
    img[0] = ins(1, 12'h12);  img[1] = ins(2, 12'h13);
    img[2] = ins(1, 12'h14);  img[3] = ins(4, 12'h17);
    img[4] = ins(2, 12'h16);  img[5] = ins(10, 0);
    img[6] = ins(1, 12'h15);  img[7] = ins(11, 12'h13);
    img[8] = ins(2, 12'h15);  img[9] = ins(1, 12'h13);
    img[10] = ins(3, 12'h17); img[11] = ins(2, 12'h13);
    img[12] = ins(1, 12'h16); img[13] = ins(4, 12'h17);
    img[14] = ins(2, 12'h16); img[15] = ins(8, 12'h000);
    img[16] = ins(9, 12'h006); img[17] = ins(7, 0);
    img[18] = 16'h0018; img[20] = 16'd5; img[23] = 16'd1;
    img[24] = 16'd10; img[25] = 16'd15; img[26] = 16'd20;
    img[27] = 16'd25; img[28] = 16'd30;
    in_mode = 0;
    start_prog();
    finish_prog();
    chk(mem[12'h15] == 16'd100, "R4", "indirect sum", mem[12'h15], 100);

    // R6: call, output, indirect return
    clear_img();
    img[0] = ins(1, 12'h20); img[1] = ins(0, 12'h10);
    img[2] = ins(2, 12'h21); img[3] = ins(7, 0);
    img[12'h11] = ins(3, 12'h22); img[12'h12] = ins(6, 0);
    img[12'h13] = ins(12, 12'h10);
    img[12'h20] = 16'd7; img[12'h22] = 16'd5;
    start_prog();
    finish_prog();
    chk(mem[12'h10] == 16'h0002, "R6", "return address saved", mem[12'h10], 2);
    chk(mem[12'h21] == 16'd12, "R6", "result after return", mem[12'h21], 12);
    chk(cap[cap0 % 2048] == 8'h0C, "R9", "subroutine output", cap[cap0 % 2048], 12);

    // R3 R7: wrap-around arithmetic and clear
    clear_img();
    img[0] = ins(1, 12'h20); img[1] = ins(3, 12'h21); img[2] = ins(2, 12'h22);
    img[3] = ins(4, 12'h21); img[4] = ins(2, 12'h23); img[5] = ins(1, 12'h24);
    img[6] = ins(4, 12'h21); img[7] = ins(2, 12'h25); img[8] = ins(10, 0);
    img[9] = ins(2, 12'h26); img[10] = ins(7, 0);
    img[12'h20] = 16'h7FFF; img[12'h21] = 16'h0001; img[12'h26] = 16'h1234;
    start_prog();
    finish_prog();
    chk(mem[12'h22] == 16'h8000, "R3", "0x7FFF+1", mem[12'h22], 16'h8000);
    chk(mem[12'h23] == 16'h7FFF, "R3", "0x8000-1", mem[12'h23], 16'h7FFF);
    chk(mem[12'h25] == 16'hFFFF, "R3", "0-1", mem[12'h25], 16'hFFFF);
    chk(mem[12'h26] == 16'h0000, "R7", "clear", mem[12'h26], 0);

    // R11: wrap from 0xFFF to 0x000, no-op opcodes
    clear_img();
    img[0] = ins(8, 12'h400); img[1] = ins(7, 0); img[2] = 16'hE0FF;
    img[3] = ins(1, 12'h30); img[4] = 16'hD123; img[5] = ins(9, 12'hFFF);
    img[12'hFFF] = ins(6, 0); img[12'h30] = 16'h0155;
    start_prog();
    finish_prog();
    chk(cap_total - cap0 == 1 && cap[cap0 % 2048] == 8'h55, "R11",
        "pc wrap then halt", cap[cap0 % 2048], 8'h55);

    // R5: code 11 never skips
    clear_img();
    img[0] = ins(1, 12'h30); img[1] = ins(8, 12'hC00); img[2] = ins(6, 0);
    img[3] = ins(7, 0); img[12'h30] = 16'h0042;
    start_prog();
    finish_prog();
    chk(cap_total - cap0 == 1, "R5", "skip code 11 not taken", cap_total - cap0, 1);

    // R8: input stalls without bus traffic, then zero-extends
    clear_img();
    img[0] = ins(5, 0); img[1] = ins(2, 12'h120); img[2] = ins(7, 0);
    img[12'h120] = 16'hFFFF;
    in_val = 8'hA5;
    in_mode = 1;
    start_prog();
    repeat (60) @(negedge clk);
    chk(acc_count - acc0 == 1 && !halted, "R8", "accesses while waiting",
        acc_count - acc0, 1);
    in_mode = 2;
    finish_prog();
    chk(mem[12'h120] == 16'h00A5, "R8", "zero-extended input", mem[12'h120], 16'h00A5);
    in_mode = 0;

    // random programs (R2 R3 R4 R5 R9 R11 via reference model)
    for (int p = 0; p < 40; p++) begin
      in_val = 8'($urandom);
      gen_random();
      start_prog();
      finish_prog();
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule